// File: doc/BRIEF.md
# SD Card Clock Divider Controller

This block derives the card-side bus clock from a reference clock by dividing it by a power of two, from 1 up to 512. Software, or a neighbouring register block, programs it through a one-cycle write strobe that carries an 8-bit divider code and a run bit. The block keeps the card clock gated low while the run bit is clear. It changes the division only while the clock is stopped, and every output edge falls on a counter wrap, so no shortened pulse ever reaches the card.

An accepted write makes the block busy. It stays busy until the new setting has taken effect at a clean clock boundary and a fixed settling interval has passed. Any write that arrives while busy is refused and flagged. The divider code is one-hot. The all-ones code asks for the undivided reference. That request is honoured only when the undivided option is enabled, and it falls back to divide-by-2 while the double-rate interface mode is active.

Top module: `sdclk_div_top`

## Requirements
- R1: After reset, card_clk is low, clk_running is 0, busy is 0, and div_exp is 9 (division by 512).
- R2: A code with a single bit b set (b = 0..7) selects exponent b+2, so code 0x80 gives 512 and 0x01 gives 4. Code 0x00 selects exponent 1. While running, card_clk has a period of 2^div_exp reference cycles and high and low phases of equal length.
- R3: Code 0xFF selects exponent 0, a card clock equal to the reference, when div1_ok=1 and dbl_rate_mode=0. With dbl_rate_mode=1 it selects exponent 1. With div1_ok=0 it is refused.
- R4: A code with two or more bits set, other than 0xFF, is refused and changes nothing.
- R5: A write whose exponent differs from the applied one is refused if the clock is running or if the write itself sets the run bit. The divider changes only while the clock is stopped.
- R6: A write received while busy is refused. wr_rej is high for the cycle after any refused write, and the refused write has no effect on div_exp, clk_running or card_clk.
- R7: busy rises in the cycle after an accepted write. It falls only once the requested setting is applied and SETTLE_CYC more cycles have elapsed. At default parameters this happens within 1000 reference cycles.
- R8: With the run bit clear, card_clk stays low and clk_running is 0.
- R9: Every high phase of card_clk lasts exactly half a period and no low phase is shorter than that. Stopping finishes the current high phase. Starting begins with a full low phase.
- R10: div_exp and clk_running report the applied setting. They change only when a change takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_code | input | 8 | Divider code (one-hot, 0x00 or 0xFF) |
| wr_run | input | 1 | Requested card clock run state |
| div1_ok | input | 1 | Permits the undivided setting |
| dbl_rate_mode | input | 1 | Double-rate interface mode active |
| card_clk | output | 1 | Divided card clock |
| busy | output | 1 | Change in progress; writes refused |
| wr_rej | output | 1 | Previous write was refused |
| div_exp | output | 4 | Applied divide exponent |
| clk_running | output | 1 | Card clock enabled |

## Verification
The hardest situation to reach is a second write landing while a stop request is still waiting for the high phase of a slow clock to end. The stimulus runs the clock at division 512, issues a stop, and writes again in the very next cycle. The refusal is seen while the pending stop is unresolved. A pulse-width monitor watches every edge of card_clk through start, stop and mode changes, so a shortened phase anywhere is caught.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int unsigned EXP_W = 4;

  typedef logic [EXP_W-1:0] exp_t;

  typedef enum logic [1:0] {
    CS_IDLE,
    CS_APPLY,
    CS_SETTLE
  } ctrl_state_e;

  typedef struct packed {
    exp_t exp;
    logic run;
  } clk_cfg_t;
endpackage

// File: rtl/sdclk_decode.sv
module sdclk_decode
  import sdclk_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic [CODE_W-1:0] code,
  input  logic              div1_ok,
  input  logic              dbl_rate,
  output exp_t              exp_o,
  output logic              valid_o
);
  logic all_ones;
  logic all_zero;
  logic single;
  exp_t bit_idx;

  assign all_ones = &code;
  assign all_zero = ~|code;
  assign single   = $onehot(code);

  always_comb begin
    bit_idx = '0;
    for (int i = 0; i < CODE_W; i++) begin
      if (code[i]) bit_idx = EXP_W'(i);
    end
  end

  always_comb begin
    exp_o   = exp_t'(1);
    valid_o = 1'b0;
    if (all_zero) begin
      exp_o   = exp_t'(1);
      valid_o = 1'b1;
    end else if (all_ones) begin
      valid_o = div1_ok;
      exp_o   = dbl_rate ? exp_t'(1) : exp_t'(0);
    end else if (single) begin
      exp_o   = bit_idx + exp_t'(2);
      valid_o = 1'b1;
    end
  end
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int unsigned MAX_EXP = 9
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     upd,
  input  clk_cfg_t tgt,
  output clk_cfg_t cur,
  output logic     done,
  output logic     card_clk
);
  localparam int unsigned CNT_W = MAX_EXP;

  clk_cfg_t           cur_q, cur_n;
  logic [CNT_W-1:0]   hcnt_q, hcnt_n;
  logic               clk_q, clk_n;
  logic [MAX_EXP:0]   full_per;
  logic [CNT_W-1:0]   half_m1;
  logic               counting;
  logic               wrap;
  logic               gate_l;
  logic               div1_sel;

  assign full_per = {{MAX_EXP{1'b0}}, 1'b1} << cur_q.exp;
  assign half_m1  = full_per[MAX_EXP:1] - {{(CNT_W-1){1'b0}}, 1'b1};
  assign counting = cur_q.run && (cur_q.exp != '0);
  assign wrap     = counting && (hcnt_q == half_m1);
  assign div1_sel = (cur_q.exp == '0);

  always_comb begin
    cur_n  = cur_q;
    hcnt_n = hcnt_q;
    clk_n  = clk_q;
    done   = 1'b0;
    if (counting) begin
      if (wrap) begin
        hcnt_n = '0;
        clk_n  = ~clk_q;
      end else begin
        hcnt_n = hcnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
      end
    end
    if (upd) begin
      if (!cur_q.run) begin
        cur_n  = tgt;
        hcnt_n = '0;
        clk_n  = 1'b0;
        done   = 1'b1;
      end else if (tgt.run) begin
        done = 1'b1;
      end else if (div1_sel) begin
        cur_n.run = 1'b0;
        done      = 1'b1;
      end else if (wrap && clk_q) begin
        cur_n.run = 1'b0;
        hcnt_n    = '0;
        clk_n     = 1'b0;
        done      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '{exp: exp_t'(MAX_EXP), run: 1'b0};
      hcnt_q <= '0;
      clk_q  <= 1'b0;
    end else begin
      cur_q  <= cur_n;
      hcnt_q <= hcnt_n;
      clk_q  <= clk_n;
    end
  end

  always_latch begin
    if (!clk) gate_l = cur_q.run && div1_sel;
  end

  assign card_clk = div1_sel ? (clk & gate_l) : clk_q;
  assign cur      = cur_q;

  // R10
  exp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_q.exp) |-> !$past(cur_q.run));

  // R9
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cur_q.run) && !div1_sel) |-> !clk_q);

  // R8
  gated_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_q.run |-> !clk_q);
endmodule

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
  import sdclk_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  logic     wr_run,
  input  exp_t     dec_exp,
  input  logic     dec_valid,
  input  clk_cfg_t gen_cur,
  input  logic     gen_done,
  input  exp_t     rst_exp,
  output clk_cfg_t tgt,
  output logic     upd,
  output logic     busy,
  output logic     wr_rej
);
  localparam int unsigned SC_W = $clog2(SETTLE_CYC + 1);

  ctrl_state_e       state_q, state_n;
  clk_cfg_t          tgt_q, tgt_n;
  logic [SC_W-1:0]   scnt_q, scnt_n;
  logic              rej_q, rej_n;
  logic              exp_change;
  logic              accept;

  assign exp_change = (dec_exp != gen_cur.exp);
  assign accept = wr_en && (state_q == CS_IDLE) && dec_valid &&
                  !(exp_change && (gen_cur.run || wr_run));

  always_comb begin
    state_n = state_q;
    tgt_n   = tgt_q;
    scnt_n  = scnt_q;
    rej_n   = wr_en && !accept;
    case (state_q)
      CS_IDLE: begin
        if (accept) begin
          tgt_n   = '{exp: dec_exp, run: wr_run};
          state_n = CS_APPLY;
        end
      end
      CS_APPLY: begin
        if (gen_done) begin
          scnt_n  = SC_W'(SETTLE_CYC - 1);
          state_n = CS_SETTLE;
        end
      end
      CS_SETTLE: begin
        if (scnt_q == '0) state_n = CS_IDLE;
        else scnt_n = scnt_q - {{(SC_W-1){1'b0}}, 1'b1};
      end
      default: state_n = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      tgt_q   <= '{exp: rst_exp, run: 1'b0};
      scnt_q  <= '0;
      rej_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      tgt_q   <= tgt_n;
      scnt_q  <= scnt_n;
      rej_q   <= rej_n;
    end
  end

  assign tgt    = tgt_q;
  assign upd    = (state_q == CS_APPLY);
  assign busy   = (state_q != CS_IDLE);
  assign wr_rej = rej_q;

  // R7
  idle_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_IDLE) |-> (gen_cur == tgt_q));

  // R6
  busy_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> (wr_rej && $stable(tgt_q)));

  // R5
  run_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_cur.run && !busy) |=> (tgt_q.exp == $past(gen_cur.exp)));
endmodule

// File: rtl/sdclk_div_top.sv
module sdclk_div_top
  import sdclk_pkg::*;
#(
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned SETTLE_CYC = 8
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_run,
  input  logic              div1_ok,
  input  logic              dbl_rate_mode,
  output logic              card_clk,
  output logic              busy,
  output logic              wr_rej,
  output logic [EXP_W-1:0]  div_exp,
  output logic              clk_running
);
  localparam int unsigned MAX_EXP = CODE_W + 1;

  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  exp_t       dec_exp;
  logic       dec_valid;
  clk_cfg_t   tgt;
  clk_cfg_t   cur;
  logic       upd;
  logic       done;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  sdclk_decode #(.CODE_W(CODE_W)) u_dec (
    .code     (wr_code),
    .div1_ok  (div1_ok),
    .dbl_rate (dbl_rate_mode),
    .exp_o    (dec_exp),
    .valid_o  (dec_valid)
  );

  sdclk_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk       (ref_clk),
    .rst_n     (core_rst_n),
    .wr_en     (wr_en),
    .wr_run    (wr_run),
    .dec_exp   (dec_exp),
    .dec_valid (dec_valid),
    .gen_cur   (cur),
    .gen_done  (done),
    .rst_exp   (exp_t'(MAX_EXP)),
    .tgt       (tgt),
    .upd       (upd),
    .busy      (busy),
    .wr_rej    (wr_rej)
  );

  sdclk_gen #(.MAX_EXP(MAX_EXP)) u_gen (
    .clk      (ref_clk),
    .rst_n    (core_rst_n),
    .upd      (upd),
    .tgt      (tgt),
    .cur      (cur),
    .done     (done),
    .card_clk (card_clk)
  );

  assign div_exp     = cur.exp;
  assign clk_running = cur.run;

  // R2
  exp_range_chk: assert property (@(posedge ref_clk) disable iff (!core_rst_n)
    div_exp <= EXP_W'(MAX_EXP));
endmodule

// File: tb/sim_sdclk_div_top.sv
`timescale 1ns/1ps
module sim_sdclk_div_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_code = 8'h00;
  logic       wr_run = 1'b0;
  logic       div1_ok = 1'b1;
  logic       dbl_rate_mode = 1'b0;
  logic       card_clk, busy, wr_rej, clk_running;
  logic [3:0] div_exp;

  int  n_chk = 0;
  int  n_bad = 0;
  int  n_rise = 0;
  bit  mon_on = 0;
  bit  have_rise = 0;
  bit  have_fall = 0;
  realtime t_rise = 0, t_fall = 0;

  always #4 clk = ~clk;

  sdclk_div_top u0 (
    .ref_clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code),
    .wr_run(wr_run), .div1_ok(div1_ok), .dbl_rate_mode(dbl_rate_mode),
    .card_clk(card_clk), .busy(busy), .wr_rej(wr_rej),
    .div_exp(div_exp), .clk_running(clk_running)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // R9 pulse-width monitor, widths in ps
  always @(posedge card_clk) begin
    if (mon_on) begin
      n_rise++;
      if (have_fall)
        check(($realtime - t_fall) >= (4.0 * (1 << div_exp)) - 0.01, "R9 low phase",
              longint'(($realtime - t_fall) * 1000), longint'(4000.0 * (1 << div_exp)));
      t_rise = $realtime;
      have_rise = 1;
    end
  end

  always @(negedge card_clk) begin
    if (mon_on) begin
      if (have_rise) begin
        real w;
        w = $realtime - t_rise;
        check((w > (4.0 * (1 << div_exp)) - 0.01) && (w < (4.0 * (1 << div_exp)) + 0.01),
              "R9 high phase", longint'(w * 1000), longint'(4000.0 * (1 << div_exp)));
      end
      t_fall = $realtime;
      have_fall = 1;
    end
  end

  task automatic do_write(input logic [7:0] c, input logic r, output logic rej, output logic bsy);
    @(negedge clk);
    wr_en = 1'b1; wr_code = c; wr_run = r;
    @(negedge clk);
    wr_en = 1'b0;
    rej = wr_rej;
    bsy = busy;
  endtask

  task automatic wait_idle(output int polls);
    polls = 0;
    while (busy && polls < 1000) begin
      @(negedge clk);
      polls++;
    end
  endtask

  task automatic measure(output real per);
    realtime a, b;
    @(posedge card_clk); a = $realtime;
    @(posedge card_clk); b = $realtime;
    per = b - a;
  endtask

  task automatic stays_low(input int cycles, input string req);
    bit seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      #1;
      if (card_clk !== 1'b0) seen = 1;
    end
    check(!seen, req, seen, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(card_clk === 1'b0, "R1 card_clk", card_clk, 0);
    check(clk_running === 1'b0, "R1 clk_running", clk_running, 0);
    check(busy === 1'b0, "R1 busy", busy, 0);
    check(div_exp === 4'd9, "R1 div_exp", div_exp, 9);
  endtask

  task automatic t_ratio(input logic [7:0] c, input int ex, input string req);
    logic rej, bsy;
    int polls;
    real per;
    do_write(c, 1'b0, rej, bsy);
    check(!rej && bsy, {req, " accept stop-write (R7 busy)"}, {rej, bsy}, 1);
    wait_idle(polls);
    check(div_exp == ex, {req, " exponent"}, div_exp, ex);
    check(!clk_running, "R8 running flag", clk_running, 0);
    stays_low(40, "R8 gated while stopped");
    do_write(c, 1'b1, rej, bsy);
    check(!rej, {req, " accept run"}, rej, 0);
    wait_idle(polls);
    check(clk_running == 1'b1, "R10 running flag", clk_running, 1);
    measure(per);
    check((per > 8.0 * (1 << ex) - 0.01) && (per < 8.0 * (1 << ex) + 0.01),
          {req, " period ps"}, longint'(per * 1000), longint'(8000.0 * (1 << ex)));
    do_write(c, 1'b0, rej, bsy);
    wait_idle(polls);
    check(polls < 1000, "R7 idle within 1000", polls, 1000);
    check(!clk_running, "R8 stopped", clk_running, 0);
    stays_low(40, "R8 low after stop");
  endtask

  task automatic t_dbl_rate;
    logic rej, bsy;
    int polls;
    dbl_rate_mode = 1'b1;
    do_write(8'hFF, 1'b0, rej, bsy);
    wait_idle(polls);
    check(!rej && div_exp == 4'd1, "R3 0xFF under double rate -> exp 1", div_exp, 1);
    dbl_rate_mode = 1'b0;
    div1_ok = 1'b0;
    do_write(8'hFF, 1'b0, rej, bsy);
    check(rej, "R3 0xFF refused without div1_ok", rej, 1);
    check(div_exp == 4'd1, "R3 exponent kept", div_exp, 1);
    div1_ok = 1'b1;
  endtask

  task automatic t_invalid;
    logic rej, bsy;
    do_write(8'h41, 1'b0, rej, bsy);
    check(rej && !bsy, "R4 two-bit code refused", {rej, bsy}, 2);
    do_write(8'h81, 1'b0, rej, bsy);
    check(rej, "R4 0x81 refused", rej, 1);
    check(div_exp == 4'd1, "R4 exponent kept", div_exp, 1);
  endtask

  task automatic t_running_change;
    logic rej, bsy;
    int polls;
    do_write(8'h01, 1'b0, rej, bsy); wait_idle(polls);
    do_write(8'h01, 1'b1, rej, bsy); wait_idle(polls);
    do_write(8'h08, 1'b1, rej, bsy);
    check(rej, "R5 change while running refused", rej, 1);
    do_write(8'h08, 1'b0, rej, bsy);
    check(rej, "R5 change with stop while running refused", rej, 1);
    check(div_exp == 4'd2 && clk_running, "R5 state kept", {div_exp, clk_running}, 5);
    do_write(8'h01, 1'b0, rej, bsy); wait_idle(polls);
    do_write(8'h08, 1'b1, rej, bsy);
    check(rej, "R5 change with run bit refused", rej, 1);
    check(div_exp == 4'd2 && !clk_running, "R5 stopped state kept", {div_exp, clk_running}, 4);
  endtask

  task automatic t_busy;
    logic rej, bsy;
    int polls, r0;
    real per;
    do_write(8'h80, 1'b0, rej, bsy); wait_idle(polls);
    do_write(8'h80, 1'b1, rej, bsy); wait_idle(polls);
    measure(per);
    do_write(8'h80, 1'b0, rej, bsy);
    check(!rej && bsy, "R7 busy after stop write", {rej, bsy}, 1);
    do_write(8'h01, 1'b0, rej, bsy);
    check(rej, "R6 write while busy refused", rej, 1);
    wait_idle(polls);
    check(polls < 1000, "R7 stop at /512 settles", polls, 1000);
    check(div_exp == 4'd9, "R6 refused write had no effect", div_exp, 9);
    check(!clk_running, "R10 stopped after settle", clk_running, 0);
    r0 = n_rise;
    repeat (600) @(negedge clk);
    check(n_rise == r0, "R9 no edge after stop", n_rise - r0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R7: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mon_on = 1;
    t_reset();
    t_ratio(8'h80, 9, "R2 code 0x80");
    t_ratio(8'h10, 6, "R2 code 0x10");
    t_ratio(8'h01, 2, "R2 code 0x01");
    t_ratio(8'h00, 1, "R2 code 0x00");
    t_ratio(8'hFF, 0, "R3 code 0xFF");
    t_dbl_rate();
    t_invalid();
    t_running_change();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule